// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block advances an unsigned non-restoring division by one quotient bit per clock. A single step takes a divisor, a partial remainder and three flag bits: a sign/carry flag (Q), the divisor-sign flag (M) and the quotient bit (T). It shifts the remainder left with T entering the low bit, then adds or subtracts the divisor depending on whether the old Q matches M. It returns the new remainder, the new Q and the new T. M passes through unchanged, so it has no output.

Two paths share the same combinational step. The single-step port registers one step's result and raises a one-cycle done strobe. The divide path runs W steps back to back with Q, M and T cleared at the start. Each step takes the next dividend bit from the top of a shift register that rotates in the T bits produced so far. At the end this path presents the full unsigned quotient. Signed-divide setup and remainder correction are left to the surrounding logic.

Top module: `nrdiv_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, step_done, div_busy and div_done are 0 and step_rem, step_q, step_t and quotient are all zero.
- R2: When step_go is high at a rising edge, step_rem holds the new remainder from that edge on. The new remainder is the shifted value S = {step_rem_in[W-2:0], step_t_in} minus step_dvs if step_q_in equals step_m, and S plus step_dvs otherwise, both modulo 2^W. step_done is high in exactly the cycles that follow an edge where step_go was high.
- R3: The new step_q is step_rem_in[W-1] XOR c XOR step_m. After a subtract, c is the borrow out of S minus step_dvs. After an add, c is the carry out of S plus step_dvs.
- R4: The new step_t is 1 when the new step_q equals step_m, and 0 otherwise.
- R5: After an edge where step_go is low, step_rem, step_q and step_t keep their values whatever the other step inputs do.
- R6: When div_go is high at an edge and the divide path is idle, div_busy rises at that edge. div_done is high for exactly one cycle, W edges later, in the same cycle that div_busy falls.
- R7: Once div_done is high, quotient equals floor(dividend / divisor) for the operands sampled with div_go, when divisor is nonzero. The value holds until the next accepted div_go.
- R8: A div_go pulse while div_busy is high is ignored. The running divide keeps its operands and its timing.
- R9: A divisor of zero yields a quotient of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_go | input | 1 | Perform one step at this edge |
| step_rem_in | input | W | Partial remainder before the step |
| step_dvs | input | W | Divisor for the step |
| step_q_in | input | 1 | Q flag before the step |
| step_m | input | 1 | M flag (divisor sign) |
| step_t_in | input | 1 | T flag before the step; enters remainder bit 0 |
| step_done | output | 1 | Step result is valid this cycle |
| step_rem | output | W | Partial remainder after the step |
| step_q | output | 1 | Q flag after the step |
| step_t | output | 1 | T flag (quotient bit) after the step |
| div_go | input | 1 | Start a full unsigned divide |
| dividend | input | W | Dividend, sampled with div_go |
| divisor | input | W | Divisor, sampled with div_go |
| div_busy | output | 1 | Divide in progress |
| div_done | output | 1 | Quotient valid, one-cycle strobe |
| quotient | output | W | Unsigned quotient |

## Verification
A single step's remainder, Q, T and done strobe all come from one register stage. The bench drives step_go at a falling edge and samples all four one falling edge later. It samples again one edge after that to see done drop and the results hold while the inputs change. For a divide, the bench counts falling edges from the one after the start edge. It expects div_done on exactly the W-th count and samples the quotient there, then checks one cycle later that done has cleared and the quotient has held. The R8 test injects a second start while the divide is running. The bench then expects the original operands' quotient at the same count.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    // direction of the arithmetic in one step
    typedef enum logic {
        DIR_ADD = 1'b0,
        DIR_SUB = 1'b1
    } nrdiv_dir_e;

    // direction rule: matching Q and M means the remainder and divisor agree in sign
    function automatic nrdiv_dir_e pick_dir(input logic q, input logic m);
        return (q == m) ? DIR_SUB : DIR_ADD;
    endfunction

endpackage

// File: rtl/nrdiv_step_core.sv
module nrdiv_step_core
    import nrdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] dvs_i,
    input  logic         q_i,
    input  logic         m_i,
    input  logic         t_i,
    output logic [W-1:0] rem_o,
    output logic         q_o,
    output logic         t_o
);

    logic         top_bit;
    logic [W-1:0] shifted;
    logic [W-1:0] sum;
    logic         cy;
    nrdiv_dir_e   dir;

    always_comb begin
        top_bit = rem_i[W-1];
        shifted = {rem_i[W-2:0], t_i};
        dir     = pick_dir(q_i, m_i);
        if (dir == DIR_SUB) begin
            sum = shifted - dvs_i;
            cy  = (sum > shifted);     // borrow out
        end else begin
            sum = shifted + dvs_i;
            cy  = (sum < shifted);     // carry out
        end
        rem_o = sum;
        q_o   = top_bit ^ cy ^ m_i;
        t_o   = (q_o == m_i);
    end

endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient
);

    localparam int             CNT_W = (W > 2) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic [W-1:0]     rem;
        logic [W-1:0]     bits;   // dividend bits out the top, quotient bits in the bottom
        logic [W-1:0]     dvs;
        logic             q;
        logic             t;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [W-1:0] core_rem;
    logic         core_q;
    logic         core_t;

    nrdiv_step_core #(.W(W)) core_i (
        .rem_i (st_q.rem),
        .dvs_i (st_q.dvs),
        .q_i   (st_q.q),
        .m_i   (1'b0),
        .t_i   (st_q.bits[W-1]),
        .rem_o (core_rem),
        .q_o   (core_q),
        .t_o   (core_t)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.bits = {st_q.bits[W-2:0], st_q.t};
            st_d.rem  = core_rem;
            st_d.q    = core_q;
            st_d.t    = core_t;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (go) begin
            st_d.rem  = '0;
            st_d.bits = dividend;
            st_d.dvs  = divisor;
            st_d.q    = 1'b0;
            st_d.t    = 1'b0;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign quotient = {st_q.bits[W-2:0], st_q.t};

endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_go,
    input  logic [W-1:0] step_rem_in,
    input  logic [W-1:0] step_dvs,
    input  logic         step_q_in,
    input  logic         step_m,
    input  logic         step_t_in,
    output logic         step_done,
    output logic [W-1:0] step_rem,
    output logic         step_q,
    output logic         step_t,
    input  logic         div_go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         div_busy,
    output logic         div_done,
    output logic [W-1:0] quotient
);

    typedef struct packed {
        logic [W-1:0] rem;
        logic         q;
        logic         t;
        logic         done;
    } step_st_t;

    step_st_t st_d, st_q;

    logic [W-1:0] core_rem;
    logic         core_q;
    logic         core_t;

    nrdiv_step_core #(.W(W)) step_core_i (
        .rem_i (step_rem_in),
        .dvs_i (step_dvs),
        .q_i   (step_q_in),
        .m_i   (step_m),
        .t_i   (step_t_in),
        .rem_o (core_rem),
        .q_o   (core_q),
        .t_o   (core_t)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = step_go;
        if (step_go) begin
            st_d.rem = core_rem;
            st_d.q   = core_q;
            st_d.t   = core_t;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_done = st_q.done;
    assign step_rem  = st_q.rem;
    assign step_q    = st_q.q;
    assign step_t    = st_q.t;

    nrdiv_seq #(.W(W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (divisor),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (quotient)
    );

endmodule

// File: rtl/nrdiv_top_chk.sv
module nrdiv_top_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         step_go,
    input logic         step_m,
    input logic         step_done,
    input logic [W-1:0] step_rem,
    input logic         step_q,
    input logic         step_t,
    input logic         div_go,
    input logic         div_busy,
    input logic         div_done,
    input logic [W-1:0] quotient
);

    localparam int BC_W = $clog2(W + 1) + 1;

    logic            armed_q;
    logic [BC_W-1:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            busy_cnt_q <= '0;
        end else begin
            armed_q    <= 1'b1;
            busy_cnt_q <= div_busy ? busy_cnt_q + 1'b1 : '0;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (!step_done && !div_busy && !div_done));

    a_r2_done_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (step_done == $past(step_go)));

    a_r4_t_matches_q: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && step_done) |-> (step_t == (step_q == $past(step_m))));

    a_r5_hold_without_go: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(step_go)) |-> ($stable(step_rem) && $stable(step_q) && $stable(step_t)));

    a_r6_run_length: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(div_busy)) |-> (div_done && (busy_cnt_q == BC_W'(W))));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        div_done |=> !div_done);

    a_r7_quot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !$past(div_busy) && !$past(div_go)) |-> $stable(quotient));

endmodule

bind nrdiv_top nrdiv_top_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_go   (step_go),
    .step_m    (step_m),
    .step_done (step_done),
    .step_rem  (step_rem),
    .step_q    (step_q),
    .step_t    (step_t),
    .div_go    (div_go),
    .div_busy  (div_busy),
    .div_done  (div_done),
    .quotient  (quotient)
);

// File: tb/nrdiv_top_tb.sv
`timescale 1ns/1ps
module nrdiv_top_tb_top;

    localparam int W = 32;
    localparam int NVEC = 9;

    // {dividend, divisor, expected quotient}
    localparam logic [3*W-1:0] VEC [NVEC] = '{
        {32'd100,        32'd7,          32'd14},
        {32'hFFFF_FFFF,  32'd1,          32'hFFFF_FFFF},
        {32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1},
        {32'd5,          32'd10,         32'd0},
        {32'h8000_0000,  32'd3,          32'h2AAA_AAAA},
        {32'd1000000,    32'd1000,       32'd1000},
        {32'hDEAD_BEEF,  32'h10,         32'h0DEA_DBEE},
        {32'd0,          32'd5,          32'd0},
        {32'h0000_1234,  32'd0,          32'hFFFF_FFFF}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         step_go = 1'b0;
    logic [W-1:0] step_rem_in = '0;
    logic [W-1:0] step_dvs = '0;
    logic         step_q_in = 1'b0;
    logic         step_m = 1'b0;
    logic         step_t_in = 1'b0;
    logic         step_done;
    logic [W-1:0] step_rem;
    logic         step_q;
    logic         step_t;
    logic         div_go = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         div_busy;
    logic         div_done;
    logic [W-1:0] quotient;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    nrdiv_top #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .step_go(step_go), .step_rem_in(step_rem_in), .step_dvs(step_dvs),
        .step_q_in(step_q_in), .step_m(step_m), .step_t_in(step_t_in),
        .step_done(step_done), .step_rem(step_rem), .step_q(step_q), .step_t(step_t),
        .div_go(div_go), .dividend(dividend), .divisor(divisor),
        .div_busy(div_busy), .div_done(div_done), .quotient(quotient)
    );

    task automatic check_eq(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // expected single step, from the requirement text (R2, R3, R4)
    task automatic ref_step(input logic [W-1:0] r, input logic [W-1:0] d,
                            input logic qi, input logic mi, input logic ti,
                            output logic [W-1:0] er, output logic eq, output logic et);
        logic [W:0] wide;
        logic [W-1:0] s;
        s = {r[W-2:0], ti};
        if (qi == mi) wide = {1'b0, s} - {1'b0, d};
        else          wide = {1'b0, s} + {1'b0, d};
        er = wide[W-1:0];
        eq = r[W-1] ^ wide[W] ^ mi;
        et = (eq == mi);
    endtask

    task automatic run_step(input logic [W-1:0] r, input logic [W-1:0] d,
                            input logic qi, input logic mi, input logic ti);
        logic [W-1:0] er;
        logic eq, et;
        ref_step(r, d, qi, mi, ti, er, eq, et);
        @(negedge clk);
        step_go = 1'b1; step_rem_in = r; step_dvs = d;
        step_q_in = qi; step_m = mi; step_t_in = ti;
        @(negedge clk);
        step_go = 1'b0; step_rem_in = ~r; step_dvs = ~d;
        step_q_in = ~qi; step_m = ~mi; step_t_in = ~ti;
        check_eq("R2 step remainder", step_rem, er);
        check_eq("R3 step Q", W'(step_q), W'(eq));
        check_eq("R4 step T", W'(step_t), W'(et));
        check_eq("R2 step_done high", W'(step_done), W'(1));
        @(negedge clk);
        check_eq("R2 step_done single", W'(step_done), W'(0));
        check_eq("R5 remainder held", step_rem, er);
        check_eq("R5 flags held", W'({step_q, step_t}), W'({eq, et}));
    endtask

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic [W-1:0] exp, input string req, input int inject_at);
        int n;
        @(negedge clk);
        div_go = 1'b1; dividend = a; divisor = b;
        @(negedge clk);
        div_go = 1'b0;
        check_eq("R6 busy after start", W'(div_busy), W'(1));
        n = 0;
        for (int k = 0; k < W + 4; k++) begin
            @(negedge clk);
            n++;
            div_go = 1'b0;
            if (div_done) break;
            if (n == inject_at) begin
                div_go = 1'b1; dividend = ~a; divisor = a | 32'h1;
            end
        end
        div_go = 1'b0;
        check_eq("R6 done latency", W'(n), W'(W));
        check_eq("R6 busy low at done", W'(div_busy), W'(0));
        check_eq(req, quotient, exp);
        dividend = ~a; divisor = ~b;
        @(negedge clk);
        check_eq("R6 done single cycle", W'(div_done), W'(0));
        check_eq("R7 quotient held", quotient, exp);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, e;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1 reset step outputs", step_rem, '0);
        check_eq("R1 reset flags", W'({step_done, step_q, step_t, div_busy, div_done}), '0);
        check_eq("R1 reset quotient", quotient, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 first cycle idle", W'({step_done, div_busy, div_done}), '0);

        // table-driven divides (R7, R9)
        for (int i = 0; i < NVEC; i++) begin
            a = VEC[i][3*W-1:2*W];
            b = VEC[i][2*W-1:W];
            e = VEC[i][W-1:0];
            run_div(a, b, e, (b == '0) ? "R9 zero divisor quotient" : "R7 table quotient", -1);
        end

        // directed single steps (R2..R5)
        run_step(32'h8000_0000, 32'd1,          1'b0, 1'b0, 1'b1); // subtract, msb set
        run_step(32'h0000_0001, 32'h0000_0005,  1'b0, 1'b0, 1'b0); // subtract with borrow
        run_step(32'h7FFF_FFFF, 32'h0000_0002,  1'b1, 1'b0, 1'b1); // add with carry
        run_step(32'h4000_0000, 32'h8000_0000,  1'b0, 1'b1, 1'b0); // add, M=1
        run_step(32'hC000_0000, 32'hF000_0000,  1'b1, 1'b1, 1'b1); // subtract, M=1
        run_step(32'h0000_0000, 32'h0000_0000,  1'b0, 1'b0, 1'b0); // zero case
        for (int i = 0; i < 16; i++) begin
            run_step($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R8: second start while running is ignored
        run_div(32'd123456789, 32'd1000, 32'd123456, "R8 quotient after ignored start", 5);

        // random divides (R7, R9)
        for (int i = 0; i < 40; i++) begin
            a = $urandom;
            b = (i % 3 == 0) ? ($urandom >> ($urandom % 31)) : $urandom;
            e = (b == '0) ? '1 : a / b;
            run_div(a, b, e, "R7 random quotient", -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule